// File: doc/BRIEF.md
# Two-Wire Register Slave with Write-Enable Interlock

This block is a two-wire serial (I2C) slave that sits in front of two 8-bit control registers. It samples the clock and data lines on the system clock and recognises start and stop conditions. After each start it collects a device address byte. When the address matches, it takes a word address byte that selects one of the registers. The master can then write one data byte, or issue a repeated start and read the selected register back. The slave drives the data line only by pulling it low, so `sda_oe` is meant to control an open-drain pad.

There are two registers. The status register sits at word address 0x00. The shutdown register sits at word address 0xFF. Bit 1 of the status register is a write-enable latch. A write to the shutdown register takes effect only if that bit was already set before the write. Other word addresses are acknowledged, but they hold nothing. Both register values are brought out on ports for the logic they control.

Top module: `i2c_gated_regif`

## Requirements
- R1: A falling SDA while SCL is high is a start and a rising SDA while SCL is high is a stop; SDA changes while SCL is low are data bits and never count as conditions.
- R2: After reset, and after any stop, the slave ignores all bus traffic and never pulls SDA low until it sees a start condition.
- R3: The address byte is decoded MSB first: bits 7..4 must be 4'b1010, bits 3..1 must equal `strap_sel[2:0]`, and bit 0 selects read (1) or write (0). On a match the slave acknowledges.
- R4: An address byte whose type or select bits differ is not acknowledged. The slave then acknowledges nothing until the next start.
- R5: The acknowledge holds SDA low for the whole ninth SCL pulse. The slave's drive on SDA changes only while SCL is low, and it releases SDA after the ninth pulse.
- R6: A write acknowledges the address, the word address and one data byte. Any further byte before the next start or stop is not acknowledged and is not written.
- R7: Word address 0x00 selects the status register and 0xFF selects the shutdown register. Any other word address is acknowledged, writes to it change nothing, and reads from it return 0x00.
- R8: A write to the shutdown register is applied only if status bit 1 (write-enable latch) was already 1 before the write. Otherwise the shutdown register keeps its value.
- R9: A read shifts out the register selected by the last word address, MSB first. A master acknowledge repeats the same register. A master no-acknowledge makes the slave release SDA and go idle.
- R10: A start received in the middle of a byte abandons that byte and restarts address reception.
- R11: A stop received in the middle of a byte returns the slave to idle and writes nothing.
- R12: Reset clears both registers to 0x00 and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, sampled |
| sda_i | input | 1 | Serial data line, sampled (the wired bus level) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_sel | input | 3 | Board strap pins compared with address bits 3..1 |
| stat_q | output | 8 | Status register contents; bit 1 is the write-enable latch |
| shdn_q | output | 8 | Shutdown register contents |

## Verification
The bench writes the shutdown register while the latch is clear and checks that the value stays put. A design that tests the latch after the status write, or not at all, would let that write through. It checks that an address miss is followed by silence on the next byte, and that a second data byte is refused. A design that kept counting bytes after a miss or after one data byte would acknowledge them. It cuts a byte short with a repeated start and with a stop, and then checks the registers. A design that committed on a partial shift, or that missed a start in mid-byte, would corrupt the status register or drop the restarted write. Reads from an unmapped address, and reads repeated on a master acknowledge, check that the right register is reloaded and that the bus is released on a no-acknowledge.

// File: rtl/i2c_gated_regif_pkg.sv
package i2c_gated_regif_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } seq_t;

   typedef enum logic [1:0] {
      BY_DEV,
      BY_WORD,
      BY_DATA
   } byte_t;
endpackage

// File: rtl/i2c_busmon.sv
module i2c_busmon #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic cond_start,
   output logic cond_stop
);
   localparam int unsigned LINES = 2;

   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $error("i2c_busmon: SYNC_STAGES must be at least 2");
   end

   logic [LINES-1:0] raw;
   logic [LINES-1:0] lvl;
   logic [LINES-1:0] lvl_q;

   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
      end
      assign lvl[g] = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '1;
      else        lvl_q <= lvl;
   end

   assign scl_lvl    = lvl[1];
   assign sda_lvl    = lvl[0];
   assign scl_rise   =  lvl[1] & ~lvl_q[1];
   assign scl_fall   = ~lvl[1] &  lvl_q[1];
   assign cond_start =  lvl[1] &  lvl_q[1] &  lvl_q[0] & ~lvl[0];
   assign cond_stop  =  lvl[1] &  lvl_q[1] & ~lvl_q[0] &  lvl[0];

   AST_COND_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_start || cond_stop) |-> $past(scl_lvl)) else $error("condition seen with SCL low"); // R1
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
   parameter logic [7:0] STAT_ADDR = 8'h00,
   parameter logic [7:0] SHDN_ADDR = 8'hFF,
   parameter int unsigned WEL_BIT  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [7:0] rd_addr,
   output logic [7:0] rd_data,
   output logic [7:0] stat_q,
   output logic [7:0] shdn_q
);
   initial begin : p_param_chk
      assert (STAT_ADDR != SHDN_ADDR) else $error("i2c_regbank: register addresses collide");
      assert (WEL_BIT < 8) else $error("i2c_regbank: WEL_BIT out of range");
   end

   logic hit_stat;
   logic hit_shdn;
   logic shdn_open;

   assign hit_stat  = (wr_addr == STAT_ADDR);
   assign hit_shdn  = (wr_addr == SHDN_ADDR);
   assign shdn_open = stat_q[WEL_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         shdn_q <= '0;
      end else if (wr_en) begin
         if (hit_stat)                    stat_q <= wr_data;
         else if (hit_shdn && shdn_open)  shdn_q <= wr_data;
      end
   end

   always_comb begin
      if (rd_addr == STAT_ADDR)      rd_data = stat_q;
      else if (rd_addr == SHDN_ADDR) rd_data = shdn_q;
      else                           rd_data = '0;
   end

   AST_SHDN_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_q != $past(shdn_q)) |-> $past(stat_q[WEL_BIT])) else $error("shutdown written while locked"); // R8
   AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit_stat && !hit_shdn) |=> ($stable(stat_q) && $stable(shdn_q))) else $error("unmapped write changed state"); // R7
endmodule

// File: rtl/i2c_gated_regif.sv
module i2c_gated_regif #(
   parameter logic [3:0]  DEV_TYPE    = 4'b1010,
   parameter logic [7:0]  STAT_ADDR   = 8'h00,
   parameter logic [7:0]  SHDN_ADDR   = 8'hFF,
   parameter int unsigned WEL_BIT     = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_sel,
   output logic [7:0] stat_q,
   output logic [7:0] shdn_q
);
   import i2c_gated_regif_pkg::*;

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

   initial begin : p_param_chk
      assert (BYTE_W == 8) else $error("i2c_gated_regif: byte width must be 8");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, cond_start, cond_stop;

   i2c_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_lvl    (scl_lvl),
      .sda_lvl    (sda_lvl),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .cond_start (cond_start),
      .cond_stop  (cond_stop)
   );

   seq_t             state;
   byte_t            kind;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       sh;
   logic [7:0]       ptr;
   logic [7:0]       tx;
   logic             rw;
   logic             mack;
   logic             oe;
   logic [7:0]       rd_data;
   logic             wr_en;
   logic             dev_hit;
   logic             byte_done;

   assign dev_hit   = (sh[7:4] == DEV_TYPE) && (sh[3:1] == strap_sel);
   assign byte_done = (state == ST_RX) && scl_fall && (cnt == CNT_FULL);
   assign wr_en     = byte_done && (kind == BY_DATA);
   assign sda_oe    = oe;

   i2c_regbank #(
      .STAT_ADDR (STAT_ADDR),
      .SHDN_ADDR (SHDN_ADDR),
      .WEL_BIT   (WEL_BIT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (ptr),
      .wr_data (sh),
      .rd_addr (ptr),
      .rd_data (rd_data),
      .stat_q  (stat_q),
      .shdn_q  (shdn_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         kind  <= BY_DEV;
         cnt   <= '0;
         sh    <= '0;
         ptr   <= '0;
         tx    <= '0;
         rw    <= 1'b0;
         mack  <= 1'b0;
         oe    <= 1'b0;
      end else if (cond_start) begin
         state <= ST_RX;
         kind  <= BY_DEV;
         cnt   <= '0;
         oe    <= 1'b0;
      end else if (cond_stop) begin
         state <= ST_IDLE;
         cnt   <= '0;
         oe    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: ;
            ST_RX: begin
               if (scl_rise && (cnt < CNT_FULL)) begin
                  sh  <= {sh[6:0], sda_lvl};
                  cnt <= cnt + 1'b1;
               end else if (byte_done) begin
                  cnt <= '0;
                  unique case (kind)
                     BY_DEV: begin
                        if (dev_hit) begin
                           rw    <= sh[0];
                           oe    <= 1'b1;
                           state <= ST_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end
                     BY_WORD: begin
                        ptr   <= sh;
                        oe    <= 1'b1;
                        state <= ST_ACK;
                     end
                     default: begin
                        oe    <= 1'b1;
                        state <= ST_ACK;
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  oe  <= 1'b0;
                  cnt <= '0;
                  unique case (kind)
                     BY_DEV: begin
                        if (rw) begin
                           tx    <= rd_data;
                           oe    <= ~rd_data[7];
                           state <= ST_TX;
                        end else begin
                           kind  <= BY_WORD;
                           state <= ST_RX;
                        end
                     end
                     BY_WORD: begin
                        kind  <= BY_DATA;
                        state <= ST_RX;
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  cnt <= cnt + 1'b1;
               end else if (scl_fall) begin
                  if (cnt == CNT_FULL) begin
                     oe    <= 1'b0;
                     cnt   <= '0;
                     state <= ST_MACK;
                  end else begin
                     oe <= ~tx[3'd7 - cnt[2:0]];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  mack <= ~sda_lvl;
               end else if (scl_fall) begin
                  if (mack) begin
                     tx    <= rd_data;
                     oe    <= ~rd_data[7];
                     state <= ST_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !oe) else $error("SDA driven while idle"); // R2
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (oe != $past(oe)) |-> !$past(scl_lvl)) else $error("SDA drive changed with SCL high"); // R5
   AST_NACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && (kind == BY_DEV) && !dev_hit) |=> ((state == ST_IDLE) && !oe)) else $error("address miss acknowledged"); // R4
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL) else $error("bit counter overflow"); // R6
   AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cond_stop) |-> (state == ST_IDLE)) else $error("stop did not idle"); // R11
   AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cond_start) |-> ((state == ST_RX) && (kind == BY_DEV) && (cnt == '0))) else $error("start did not restart"); // R10
endmodule

// File: tb/tb_i2c_gated_regif.sv
module tb_i2c_gated_regif;
   localparam int CLK_NS = 10;
   localparam int Q      = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_oe;
   logic [2:0] strap_sel = 3'b101;
   logic [7:0] stat_q;
   logic [7:0] shdn_q;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   assign sda_line = sda_m & ~sda_oe;

   always #(CLK_NS/2) clk = ~clk;

   i2c_gated_regif dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .strap_sel (strap_sel),
      .stat_q    (stat_q),
      .shdn_q    (shdn_q)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      if (!scl_m) begin
         sda_m = 1'b1; wq(Q);
         scl_m = 1'b1; wq(Q);
      end
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(2*Q);
   endtask

   task automatic send_bit(input bit b);
      sda_m = b;    wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, output bit ack, output bit oe_seen);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      ack     = !sda_line;
      oe_seen = sda_oe;
      wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic rd_byte(input bit give_ack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(Q);
         scl_m = 1'b1; wq(Q);
         d[i] = sda_line;
         wq(Q);
         scl_m = 1'b0;
      end
      wq(Q);
      sda_m = !give_ack; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
      sda_m = 1'b1;
   endtask

   task automatic reg_write(input logic [7:0] wa, input logic [7:0] d, output logic [2:0] acks);
      bit a, o;
      i2c_start();
      wr_byte(8'hAA, a, o); acks[2] = a;
      wr_byte(wa, a, o);    acks[1] = a;
      wr_byte(d, a, o);     acks[0] = a;
      i2c_stop();
   endtask

   task automatic reg_read(input logic [7:0] wa, output logic [7:0] d);
      bit a, o;
      i2c_start();
      wr_byte(8'hAA, a, o);
      wr_byte(wa, a, o);
      i2c_start();
      wr_byte(8'hAB, a, o);
      rd_byte(1'b0, d);
      i2c_stop();
   endtask

   task automatic t_reset();
      chk(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
      chk(stat_q == 8'h00, "R12 status cleared", stat_q, 0);
      chk(shdn_q == 8'h00, "R12 shutdown cleared", shdn_q, 0);
   endtask

   task automatic t_no_start();
      bit a, o;
      scl_m = 1'b0; wq(Q);
      wr_byte(8'hAA, a, o);
      chk(a == 1'b0, "R2 no ack before start", a, 0);
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(2*Q);
   endtask

   task automatic t_write_status();
      bit a, o;
      i2c_start();
      wr_byte(8'hAA, a, o);
      chk(a && o, "R3 address acked with drive", {a, o}, 2'b11);
      chk(sda_oe == 1'b0, "R5 released after ack", sda_oe, 0);
      wr_byte(8'h00, a, o);
      chk(a, "R6 word address acked", a, 1);
      wr_byte(8'h5C, a, o);
      chk(a, "R6 data acked", a, 1);
      chk(sda_oe == 1'b0, "R5 released after data ack", sda_oe, 0);
      i2c_stop();
      chk(stat_q == 8'h5C, "R7 R1 status written", stat_q, 8'h5C);
   endtask

   task automatic t_shdn_gate();
      logic [2:0] acks;
      logic [7:0] d;
      reg_write(8'hFF, 8'h3C, acks);
      chk(acks == 3'b111, "R8 locked write acked", acks, 3'b111);
      chk(shdn_q == 8'h00, "R8 locked write ignored", shdn_q, 0);
      reg_write(8'h00, 8'h02, acks);
      chk(stat_q == 8'h02, "R8 latch set", stat_q, 8'h02);
      reg_write(8'hFF, 8'hA5, acks);
      chk(shdn_q == 8'hA5, "R8 unlocked write applied", shdn_q, 8'hA5);
      reg_read(8'h00, d);
      chk(d == 8'h02, "R9 read status", d, 8'h02);
      reg_read(8'hFF, d);
      chk(d == 8'hA5, "R9 R7 read shutdown", d, 8'hA5);
   endtask

   task automatic t_unmapped();
      logic [2:0] acks;
      logic [7:0] d;
      reg_write(8'h42, 8'h77, acks);
      chk(acks == 3'b111, "R7 unmapped acked", acks, 3'b111);
      chk(stat_q == 8'h02 && shdn_q == 8'hA5, "R7 unmapped write inert", {stat_q, shdn_q}, 16'h02A5);
      reg_read(8'h42, d);
      chk(d == 8'h00, "R7 unmapped read zero", d, 0);
   endtask

   task automatic t_addr_miss();
      bit a, o;
      i2c_start();
      wr_byte(8'hA6, a, o);
      chk(a == 1'b0, "R4 select mismatch nacked", a, 0);
      wr_byte(8'h00, a, o);
      chk(a == 1'b0, "R4 idle after miss", a, 0);
      i2c_stop();
      i2c_start();
      wr_byte(8'hBA, a, o);
      chk(a == 1'b0, "R4 type mismatch nacked", a, 0);
      i2c_stop();
      strap_sel = 3'b011;
      i2c_start();
      wr_byte(8'hA6, a, o);
      chk(a == 1'b1, "R3 strap follows pins", a, 1);
      i2c_stop();
      strap_sel = 3'b101;
   endtask

   task automatic t_extra_byte();
      bit a, o;
      i2c_start();
      wr_byte(8'hAA, a, o);
      wr_byte(8'h00, a, o);
      wr_byte(8'h10, a, o);
      wr_byte(8'h99, a, o);
      chk(a == 1'b0, "R6 second data byte nacked", a, 0);
      i2c_stop();
      chk(stat_q == 8'h10, "R6 only first byte written", stat_q, 8'h10);
   endtask

   task automatic t_read_repeat();
      bit a, o;
      logic [7:0] d;
      i2c_start();
      wr_byte(8'hAA, a, o);
      wr_byte(8'h00, a, o);
      i2c_start();
      wr_byte(8'hAB, a, o);
      rd_byte(1'b1, d);
      chk(d == 8'h10, "R9 first read byte", d, 8'h10);
      rd_byte(1'b0, d);
      chk(d == 8'h10, "R9 repeated read byte", d, 8'h10);
      chk(sda_oe == 1'b0, "R9 released on nack", sda_oe, 0);
      i2c_stop();
   endtask

   task automatic t_restart_mid();
      bit a, o;
      i2c_start();
      send_bit(1); send_bit(0); send_bit(1); send_bit(0);
      i2c_start();
      wr_byte(8'hAA, a, o);
      chk(a, "R10 restart in address byte", a, 1);
      wr_byte(8'h00, a, o);
      send_bit(1); send_bit(1); send_bit(1);
      i2c_start();
      wr_byte(8'hAA, a, o);
      wr_byte(8'h00, a, o);
      wr_byte(8'h81, a, o);
      i2c_stop();
      chk(stat_q == 8'h81, "R10 write after restart", stat_q, 8'h81);
   endtask

   task automatic t_stop_mid();
      bit a, o;
      i2c_start();
      wr_byte(8'hAA, a, o);
      wr_byte(8'h00, a, o);
      send_bit(0); send_bit(1); send_bit(0); send_bit(0); send_bit(1);
      i2c_stop();
      chk(stat_q == 8'h81, "R11 R1 partial byte dropped", stat_q, 8'h81);
      chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
      scl_m = 1'b0; wq(Q);
      wr_byte(8'hAA, a, o);
      chk(a == 1'b0, "R2 idle after stop", a, 0);
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(2*Q);
   endtask

   initial begin
      wq(5);
      t_reset();
      rst_n = 1'b1;
      wq(5);
      t_no_start();
      t_write_status();
      t_shdn_gate();
      t_unmapped();
      t_addr_miss();
      t_extra_byte();
      t_read_repeat();
      t_restart_mid();
      t_stop_mid();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog R2: got %0d cycles expected fewer", 190000);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule